// File: doc/BRIEF.md
# x87 Tag Word and Empty-State Controller

This block keeps the eight 2-bit register tags of the x87 floating-point stack, plus the 3-bit top-of-stack pointer, and changes them in response to decoded instruction events. One event can be offered each clock cycle. Each event is classed as one of the following:

- the empty-state instruction (opcode bytes 0F 77, no operands);
- another MMX instruction;
- an x87 load, which pushes a value;
- an x87 pop.

Before any state changes, the block checks the event against the prefix bits (LOCK, and any 66/F2/F3 mandatory prefix) and against the control bits (CR0.EM, CR0.TS, and a pending floating-point exception). An event that fails a check raises exactly one fault bit and changes nothing.

Events arrive on a valid/ready pair. `ev_ready` is held high because the block takes an event on every cycle, so it never applies back-pressure. An event is taken on the rising edge where `ev_valid` is high. Its results appear on the registered outputs one cycle later:

- `commit`, the commit strobe;
- `fault`, the fault vector;
- `stk_ovf`, the stack-overflow flag;
- `tag_word` and `stk_top`, which show the updated state.

A load that targets a register whose tag is not empty is flagged as a stack overflow and leaves the state untouched. This catches an x87 load issued after MMX use without the empty-state instruction in between. The block behaves the same in every processor mode and has no flags output.

Top module: `x87_tag_ctrl`

## Requirements
- R1: After reset the tag word is FFFFh, the stack top is 0, `commit`, `fault` and `stk_ovf` are low, and `ev_ready` is high.
- R2: An accepted empty-state instruction sets the tag word to FFFFh (all eight tags 11 = empty), leaves the stack top unchanged and pulses `commit`.
- R3: An accepted MMX instruction other than the empty-state one sets the tag word to 0000h (all tags 00 = valid), leaves the stack top unchanged and pulses `commit`.
- R4: When CR0.EM is 1, any event raises the invalid-opcode fault, `fault` = 3'b001.
- R5: When CR0.TS is 1 and no invalid-opcode cause applies, the event raises the device-not-available fault, `fault` = 3'b010.
- R6: When an FPU exception is pending and no higher-priority cause applies, the event raises the math fault, `fault` = 3'b100.
- R7: The LOCK prefix on any event raises `fault` = 3'b001. A 66/F2/F3 mandatory prefix on the empty-state opcode also raises `fault` = 3'b001. A mandatory prefix on any other class has no effect.
- R8: At most one `fault` bit is ever high. A faulted event changes neither the tag word nor the stack top and gives no `commit`.
- R9: An accepted push decrements the stack top modulo 8, marks the register at the new top valid (tag 00), and pulses `commit`. Register i occupies tag-word bits [2i+1:2i].
- R10: An accepted pop marks the register at the current top empty (tag 11), increments the stack top modulo 8, and pulses `commit`.
- R11: A push whose target register (top−1 mod 8) does not have tag 11 raises `stk_ovf` for one cycle, changes no state and gives no `commit`.
- R12: Every result is due exactly one cycle after the event is accepted. With `ev_valid` low, the class inputs have no effect.
- R13: If more than one class bit is set, the event takes the first class set in this order: empty-state, MMX, push, pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_ready | output | 1 | Block accepts an event (always 1) |
| is_empty_op | input | 1 | Event is the empty-state instruction (0F 77) |
| is_mmx_op | input | 1 | Event is another MMX instruction |
| is_push | input | 1 | Event is an x87 load (push) |
| is_pop | input | 1 | Event is an x87 pop |
| pfx_lock | input | 1 | LOCK prefix present |
| pfx_mand | input | 1 | A 66, F2 or F3 prefix is present |
| cr0_em | input | 1 | Emulation control bit |
| cr0_ts | input | 1 | Task-switched control bit |
| fpu_pend | input | 1 | An FPU exception is pending |
| tag_word | output | 16 | Eight 2-bit tags; register i in bits [2i+1:2i] |
| stk_top | output | 3 | Stack-top pointer |
| fault | output | 3 | One-hot fault: bit0 invalid opcode, bit1 device not available, bit2 math |
| stk_ovf | output | 1 | Push into a register that is not empty |
| commit | output | 1 | Event accepted without fault or overflow |

## Verification
The commit strobe, the fault vector and the overflow flag are each registered once, so they are due exactly one cycle after the accepting edge. The tag word and the stack top change on that same edge. The bench drives each event on a falling edge and compares every output at the following falling edge, before it drives the next event. A result that arrives one cycle early or late is therefore read against the wrong event. The sweep includes idle cycles with the class bits set, to show that nothing moves when no event is offered.

// File: rtl/x87_tag_pkg.sv
package x87_tag_pkg;
  localparam int FLT_W  = 3;
  localparam int FLT_UD = 0;
  localparam int FLT_NM = 1;
  localparam int FLT_MF = 2;
  localparam int TAG_W  = 2;
  localparam logic [TAG_W-1:0] TAG_VALID = 2'b00;
  localparam logic [TAG_W-1:0] TAG_EMPTY = 2'b11;

  typedef enum logic [2:0] {
    OPK_NONE,
    OPK_EMPTY,
    OPK_MMX,
    OPK_PUSH,
    OPK_POP
  } op_kind_e;
endpackage

// File: rtl/x87_op_select.sv
module x87_op_select
  import x87_tag_pkg::*;
(
  input  logic     ev_valid,
  input  logic     is_empty_op,
  input  logic     is_mmx_op,
  input  logic     is_push,
  input  logic     is_pop,
  output op_kind_e kind
);
  // Priority: empty-state, MMX, push, pop (R13)
  always_comb begin
    kind = OPK_NONE;
    if (ev_valid) begin
      if (is_empty_op)    kind = OPK_EMPTY;
      else if (is_mmx_op) kind = OPK_MMX;
      else if (is_push)   kind = OPK_PUSH;
      else if (is_pop)    kind = OPK_POP;
    end
  end
endmodule

// File: rtl/x87_fault_chk.sv
module x87_fault_chk
  import x87_tag_pkg::*;
(
  input  op_kind_e         kind,
  input  logic             pfx_lock,
  input  logic             pfx_mand,
  input  logic             cr0_em,
  input  logic             cr0_ts,
  input  logic             fpu_pend,
  output logic [FLT_W-1:0] fault,
  output logic             grant
);
  logic active, ud_cause;

  assign active   = (kind != OPK_NONE);
  assign ud_cause = cr0_em | pfx_lock | ((kind == OPK_EMPTY) & pfx_mand);

  always_comb begin
    fault = '0;
    if (active) begin
      if (ud_cause)      fault[FLT_UD] = 1'b1;
      else if (cr0_ts)   fault[FLT_NM] = 1'b1;
      else if (fpu_pend) fault[FLT_MF] = 1'b1;
    end
  end

  assign grant = active & ~(|fault);

  always_comb begin
    if (active) assert_fault_pick_R8: assert ($onehot(fault) || grant);
  end
endmodule

// File: rtl/x87_tag_file.sv
module x87_tag_file
  import x87_tag_pkg::*;
#(
  parameter int NREG = 8,
  localparam int PTR_W = $clog2(NREG),
  localparam int WORD_W = NREG * TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_empty,
  input  logic              do_valid,
  input  logic              do_push,
  input  logic              do_pop,
  output logic [WORD_W-1:0] tag_word,
  output logic [PTR_W-1:0]  top,
  output logic              push_blocked
);
  logic [PTR_W-1:0] top_q, push_idx;

  assign push_idx = top_q - PTR_W'(1);

  for (genvar i = 0; i < NREG; i++) begin : g_cell
    logic [TAG_W-1:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 cell_q <= TAG_EMPTY;
      else if (do_empty)                          cell_q <= TAG_EMPTY;
      else if (do_valid)                          cell_q <= TAG_VALID;
      else if (do_push && push_idx == PTR_W'(i))  cell_q <= TAG_VALID;
      else if (do_pop && top_q == PTR_W'(i))      cell_q <= TAG_EMPTY;
    end
    assign tag_word[TAG_W*i +: TAG_W] = cell_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       top_q <= '0;
    else if (do_push) top_q <= push_idx;
    else if (do_pop)  top_q <= top_q + PTR_W'(1);
  end

  assign top          = top_q;
  assign push_blocked = (tag_word[TAG_W*push_idx +: TAG_W] != TAG_EMPTY);

  assert_empty_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
    do_empty |=> (tag_word == '1));
  assert_valid_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    do_valid |=> (tag_word == '0));
  assert_pop_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop |=> (top == $past(top) + PTR_W'(1)));
  assert_push_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |=> (top == $past(top) - PTR_W'(1)));
endmodule

// File: rtl/x87_tag_ctrl.sv
module x87_tag_ctrl
  import x87_tag_pkg::*;
#(
  parameter int NREG = 8,
  localparam int PTR_W = $clog2(NREG),
  localparam int WORD_W = NREG * TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic              is_empty_op,
  input  logic              is_mmx_op,
  input  logic              is_push,
  input  logic              is_pop,
  input  logic              pfx_lock,
  input  logic              pfx_mand,
  input  logic              cr0_em,
  input  logic              cr0_ts,
  input  logic              fpu_pend,
  output logic [WORD_W-1:0] tag_word,
  output logic [PTR_W-1:0]  stk_top,
  output logic [FLT_W-1:0]  fault,
  output logic              stk_ovf,
  output logic              commit
);
  op_kind_e         kind;
  logic [FLT_W-1:0] fault_d, fault_q;
  logic             grant, push_blocked;
  logic             do_empty, do_valid, do_push, do_pop, ovf_d, commit_d;
  logic             ovf_q, commit_q;

  assign ev_ready = 1'b1;

  x87_op_select u_sel (
    .ev_valid    (ev_valid),
    .is_empty_op (is_empty_op),
    .is_mmx_op   (is_mmx_op),
    .is_push     (is_push),
    .is_pop      (is_pop),
    .kind        (kind)
  );

  x87_fault_chk u_flt (
    .kind     (kind),
    .pfx_lock (pfx_lock),
    .pfx_mand (pfx_mand),
    .cr0_em   (cr0_em),
    .cr0_ts   (cr0_ts),
    .fpu_pend (fpu_pend),
    .fault    (fault_d),
    .grant    (grant)
  );

  assign do_empty = grant & (kind == OPK_EMPTY);
  assign do_valid = grant & (kind == OPK_MMX);
  assign ovf_d    = grant & (kind == OPK_PUSH) & push_blocked;
  assign do_push  = grant & (kind == OPK_PUSH) & ~push_blocked;
  assign do_pop   = grant & (kind == OPK_POP);
  assign commit_d = grant & ~ovf_d;

  x87_tag_file #(.NREG(NREG)) u_tags (
    .clk          (clk),
    .rst_n        (rst_n),
    .do_empty     (do_empty),
    .do_valid     (do_valid),
    .do_push      (do_push),
    .do_pop       (do_pop),
    .tag_word     (tag_word),
    .top          (stk_top),
    .push_blocked (push_blocked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q  <= '0;
      ovf_q    <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      fault_q  <= fault_d;
      ovf_q    <= ovf_d;
      commit_q <= commit_d;
    end
  end

  assign fault   = fault_q;
  assign stk_ovf = ovf_q;
  assign commit  = commit_q;

  assert_fault_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fault));
  assert_fault_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault) |-> (tag_word == $past(tag_word) && stk_top == $past(stk_top) && !commit));
  assert_em_ud_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && cr0_em && (is_empty_op || is_mmx_op || is_push || is_pop)) |=> (fault == 3'b001));
  assert_no_overflow_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stk_ovf |-> (!commit && tag_word == $past(tag_word) && stk_top == $past(stk_top)));
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> (!commit && !stk_ovf && fault == '0));
endmodule

// File: tb/tb_x87_tag_ctrl.sv
module tb_x87_tag_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 0, is_empty_op = 0, is_mmx_op = 0, is_push = 0, is_pop = 0;
  logic pfx_lock = 0, pfx_mand = 0, cr0_em = 0, cr0_ts = 0, fpu_pend = 0;
  logic        ev_ready, stk_ovf, commit;
  logic [15:0] tag_word;
  logic [2:0]  stk_top, fault;

  int checks = 0, fails = 0;
  bit done = 0;

  // Reference state
  int m_tag[8];
  int m_top;

  always #5 clk = ~clk;

  x87_tag_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .is_empty_op(is_empty_op), .is_mmx_op(is_mmx_op), .is_push(is_push), .is_pop(is_pop),
    .pfx_lock(pfx_lock), .pfx_mand(pfx_mand), .cr0_em(cr0_em), .cr0_ts(cr0_ts),
    .fpu_pend(fpu_pend), .tag_word(tag_word), .stk_top(stk_top), .fault(fault),
    .stk_ovf(stk_ovf), .commit(commit)
  );

  function automatic int model_word();
    int w = 0;
    for (int i = 0; i < 8; i++) w = w + m_tag[i] * (4 ** i);
    return w;
  endfunction

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  // Drive one event at a falling edge, check outputs at the next falling edge
  task automatic step(bit v, bit e, bit m, bit pu, bit po, bit lk, bit md, bit em, bit ts, bit pd);
    int kind, exp_fault, exp_ovf, exp_commit, tgt;
    string req;
    ev_valid = v; is_empty_op = e; is_mmx_op = m; is_push = pu; is_pop = po;
    pfx_lock = lk; pfx_mand = md; cr0_em = em; cr0_ts = ts; fpu_pend = pd;
    // R13 class priority
    kind = !v ? 0 : e ? 1 : m ? 2 : pu ? 3 : po ? 4 : 0;
    exp_fault = 0; exp_ovf = 0; exp_commit = 0; req = "R12";
    if (kind != 0) begin
      if (em)                        begin exp_fault = 1; req = "R4"; end
      else if (lk || (kind==1 && md)) begin exp_fault = 1; req = "R7"; end
      else if (ts)                   begin exp_fault = 2; req = "R5"; end
      else if (pd)                   begin exp_fault = 4; req = "R6"; end
      else begin
        case (kind)
          1: begin for (int i = 0; i < 8; i++) m_tag[i] = 3; exp_commit = 1; req = "R2"; end
          2: begin for (int i = 0; i < 8; i++) m_tag[i] = 0; exp_commit = 1; req = "R3"; end
          3: begin
               tgt = (m_top + 7) % 8;
               if (m_tag[tgt] != 3) begin exp_ovf = 1; req = "R11"; end
               else begin m_top = tgt; m_tag[tgt] = 0; exp_commit = 1; req = "R9"; end
             end
          default: begin m_tag[m_top] = 3; m_top = (m_top + 1) % 8; exp_commit = 1; req = "R10"; end
        endcase
      end
      if (exp_fault != 0) req = {req, "/R8"};
    end
    @(negedge clk);
    chk(req, "fault", int'(fault), exp_fault);
    chk(req, "commit", int'(commit), exp_commit);
    chk(req, "stk_ovf", int'(stk_ovf), exp_ovf);
    chk(req, "tag_word", int'(tag_word), model_word());
    chk(req, "stk_top", int'(stk_top), m_top);
    chk("R12", "ev_ready", int'(ev_ready), 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) m_tag[i] = 3;
    m_top = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "tag_word", int'(tag_word), 16'hFFFF);
    chk("R1", "stk_top", int'(stk_top), 0);
    chk("R1", "fault", int'(fault), 0);
    chk("R1", "commit", int'(commit), 0);
    chk("R1", "stk_ovf", int'(stk_ovf), 0);
    chk("R1", "ev_ready", int'(ev_ready), 1);

    // R9 fill the stack with eight pushes, then R11 overflow on the ninth
    for (int k = 0; k < 8; k++) step(1,0,0,1,0, 0,0,0,0,0);
    step(1,0,0,1,0, 0,0,0,0,0);
    // R10 pop then push again succeeds
    step(1,0,0,0,1, 0,0,0,0,0);
    step(1,0,0,1,0, 0,0,0,0,0);
    // R2 empty-state clears; R3 MMX marks valid; push then overflows (R11)
    step(1,1,0,0,0, 0,0,0,0,0);
    step(1,0,1,0,0, 0,0,0,0,0);
    step(1,0,0,1,0, 0,0,0,0,0);
    // R7 mandatory prefix on empty-state faults; on MMX has no effect
    step(1,1,0,0,0, 0,1,0,0,0);
    step(1,0,1,0,0, 0,1,0,0,0);
    step(1,1,0,0,0, 0,0,0,0,0);
    // R12 idle cycle with class bits set
    step(0,1,1,1,1, 0,0,0,0,0);

    // Near-exhaustive sweep of class bits, prefixes and control bits
    for (int v = 0; v < 1024; v++) begin
      step(v[9] | v[0], v[0], v[1], v[2], v[3], v[4], v[5], v[6], v[7], v[8]);
    end
    finish_run();
  end
endmodule